// File: doc/BRIEF.md
# Serial Flash Bus Front End

This block sits between the four-wire serial bus of a flash device and the device's internal controller. It runs on a fast internal clock and oversamples chip select, the serial clock, the serial input and the pause pin through a synchronizer. From the edges of the synchronized serial clock it assembles the opcode, a 24-bit address and any write bytes. Each item is handed to the controller as an event on a valid/ready handshake.

For the two read commands it fetches bytes from the controller over a second valid/ready port. It shifts them out on the falling serial-clock edges, either one bit per edge on the output pin or two bits per edge on the output pin and the repurposed input pin. It owns the tristate enables of both pins and implements the pause function. It also reports when the device may drop into standby, which is only once the bus is deselected and no self-timed internal operation is still running.

Top module: `spi_flash_frontend`

## Requirements
- R1: A transaction opens only on a high-to-low transition of chip select. If chip select is already low when reset is released, no event is produced until it has gone high and then low again.
- R2: Serial input is sampled on rising serial-clock edges, most significant bit first. The first byte of a transaction is delivered as an event of kind 0, with the opcode in ev_data_o[7:0] and the upper bits zero.
- R3: While chip select is high, both output enables are low, serial clock and input activity is ignored, and the standby decision is the only live output. A deselect before a byte boundary discards the partial byte, and the next transaction starts again at the opcode.
- R4: The opcodes 8'h02, 8'h20, 8'h03 and 8'h3B are followed by 24 address bits, delivered as a single event of kind 1 with the address in ev_data_o[23:0]. Every byte after the address of 8'h02 or 8'h20, and every byte after any other opcode, is delivered as an event of kind 2 in ev_data_o[7:0].
- R5: After the address of opcode 8'h03, bytes taken from the controller in order are driven on so_o, most significant bit first, with one new bit on each falling serial-clock edge. so_oe_o rises from the first such edge.
- R6: After the address of opcode 8'h3B, each falling edge drives two bits: the higher-order bit on so_o and the next lower bit on sio_o. Both so_oe_o and sio_oe_o are high.
- R7: A pause starts only while the device is selected and the serial clock is low. While paused, clock edges and input data are ignored and both enables are low. When hold_n_i returns high, the transfer resumes at the bit where it stopped.
- R8: Once ev_valid_o is high it stays high, with kind and data unchanged, until ev_ready_i is seen. A byte that completes while an event is still pending is dropped.
- R9: standby_o is high only while chip select is high and busy_i is low.
- R10: The serial clock may idle high (mode 3) or low (mode 0). In mode 3, the leading falling edge before the first rising edge shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for so_o |
| sio_o | output | 1 | Second data bit in dual read |
| sio_oe_o | output | 1 | Output enable for the input pin in dual read |
| ev_valid_o | output | 1 | Event valid |
| ev_kind_o | output | 2 | Event kind: 0 opcode, 1 address, 2 write byte |
| ev_data_o | output | 24 | Event payload |
| ev_ready_i | input | 1 | Controller accepts event |
| rd_valid_i | input | 1 | Controller read byte valid |
| rd_data_i | input | 8 | Controller read byte |
| rd_ready_o | output | 1 | Front end takes a read byte |
| busy_i | input | 1 | Self-timed internal operation in progress |
| standby_o | output | 1 | Device may enter standby |

## Verification
The bench opens a transaction by holding chip select low through reset. A design that treated any low level as a start would then emit a spurious opcode. It cuts a program command off mid-byte and follows it with an unrelated command, which exposes a shifter that keeps stale bits and shows up as a corrupted second opcode.

It pauses both a write byte and a single-line read mid-byte while toggling the clock and the input. A pause that leaked edges would shift extra bits, misalign every later byte, or leave the pin driven. The dual read checks the split of each bit pair between the two pins, where a swapped or one-bit-per-edge design garbles the byte. A mode 3 transaction checks that the leading falling edge adds no bit. The stalled handshake checks that a pending event is neither overwritten nor lost.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [1:0] {
    EV_OPCODE = 2'd0,
    EV_ADDR   = 2'd1,
    EV_WDATA  = 2'd2
  } ev_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_WDAT,
    ST_RD
  } rx_state_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_DREAD = 8'h3B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;

  function automatic logic op_has_addr(input logic [7:0] op);
    return (op == OP_READ) || (op == OP_DREAD) || (op == OP_PROG) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desel_i,
  input  logic              start_i,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              ev_ready_i,
  output logic              ev_valid_o,
  output logic [1:0]        ev_kind_o,
  output logic [ADDR_W-1:0] ev_data_o,
  output logic              rd_phase_o,
  output logic              dual_o
);

  localparam int ABYTES = ADDR_W / 8;
  localparam int AB_W   = (ABYTES > 1) ? $clog2(ABYTES) : 1;
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ABYTES - 1);

  rx_state_t         st_q, st_nx;
  logic [6:0]        sh_q, sh_nx;
  logic [2:0]        cnt_q, cnt_nx;
  logic [AB_W-1:0]   ab_q, ab_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              rd_q, rd_nx;
  logic              dual_q, dual_nx;
  logic              evv_q, evv_nx;
  ev_kind_t          evk_q, evk_nx;
  logic [ADDR_W-1:0] evd_q, evd_nx;

  logic [7:0]        byte_w;
  logic              shifting;
  logic              push;
  ev_kind_t          push_k;
  logic [ADDR_W-1:0] push_d;

  assign byte_w   = {sh_q, bit_i};
  assign shifting = bit_en_i && ((st_q == ST_OPC) || (st_q == ST_ADR) || (st_q == ST_WDAT));

  always_comb begin
    st_nx   = st_q;
    sh_nx   = sh_q;
    cnt_nx  = cnt_q;
    ab_nx   = ab_q;
    addr_nx = addr_q;
    rd_nx   = rd_q;
    dual_nx = dual_q;
    push    = 1'b0;
    push_k  = EV_OPCODE;
    push_d  = '0;
    if (desel_i) begin
      st_nx   = ST_IDLE;
      cnt_nx  = '0;
      rd_nx   = 1'b0;
      dual_nx = 1'b0;
    end else if (start_i) begin
      st_nx   = ST_OPC;
      cnt_nx  = '0;
      ab_nx   = '0;
      rd_nx   = 1'b0;
      dual_nx = 1'b0;
    end else if (shifting) begin
      sh_nx  = byte_w[6:0];
      cnt_nx = cnt_q + 3'd1;
      if (cnt_q == 3'd7) begin
        push = 1'b1;
        unique case (st_q)
          ST_OPC: begin
            push_k = EV_OPCODE;
            push_d = ADDR_W'(byte_w);
            rd_nx   = (byte_w == OP_READ) || (byte_w == OP_DREAD);
            dual_nx = (byte_w == OP_DREAD);
            st_nx   = op_has_addr(byte_w) ? ST_ADR : ST_WDAT;
          end
          ST_ADR: begin
            addr_nx = {addr_q[ADDR_W-9:0], byte_w};
            ab_nx   = ab_q + 1'b1;
            push    = (ab_q == AB_LAST);
            push_k  = EV_ADDR;
            push_d  = {addr_q[ADDR_W-9:0], byte_w};
            if (ab_q == AB_LAST) st_nx = rd_q ? ST_RD : ST_WDAT;
          end
          default: begin
            push_k = EV_WDATA;
            push_d = ADDR_W'(byte_w);
          end
        endcase
      end
    end
  end

  always_comb begin
    evv_nx = evv_q && !ev_ready_i;
    evk_nx = evk_q;
    evd_nx = evd_q;
    if (push && (!evv_q || ev_ready_i)) begin
      evv_nx = 1'b1;
      evk_nx = push_k;
      evd_nx = push_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      ab_q   <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      dual_q <= 1'b0;
      evv_q  <= 1'b0;
      evk_q  <= EV_OPCODE;
      evd_q  <= '0;
    end else begin
      st_q   <= st_nx;
      sh_q   <= sh_nx;
      cnt_q  <= cnt_nx;
      ab_q   <= ab_nx;
      addr_q <= addr_nx;
      rd_q   <= rd_nx;
      dual_q <= dual_nx;
      evv_q  <= evv_nx;
      evk_q  <= evk_nx;
      evd_q  <= evd_nx;
    end
  end

  assign ev_valid_o = evv_q;
  assign ev_kind_o  = evk_q;
  assign ev_data_o  = evd_q;
  assign rd_phase_o = (st_q == ST_RD);
  assign dual_o     = dual_q;

  AST_EV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evv_q && !ev_ready_i |=> evv_q && $stable(evd_q) && $stable(evk_q)); // R8

  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i && !start_i && !desel_i |=> $stable(cnt_q) && $stable(sh_q)); // R7

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_phase_i,
  input  logic       dual_i,
  input  logic       shift_en_i,
  input  logic       rd_valid_i,
  input  logic [7:0] rd_data_i,
  output logic       rd_ready_o,
  output logic       so_o,
  output logic       sio_o,
  output logic       drv_o
);

  logic [7:0] obuf_q, obuf_nx;
  logic       full_q, full_nx;
  logic [7:0] osh_q, osh_nx;
  logic [2:0] pos_q, pos_nx;
  logic       so_q, so_nx;
  logic       sio_q, sio_nx;
  logic       drv_q, drv_nx;

  logic       take;
  logic [7:0] src;
  logic [2:0] step;

  assign rd_ready_o = rd_phase_i && !full_q;
  assign take       = rd_valid_i && rd_ready_o;
  assign src        = (pos_q == 3'd0) ? obuf_q : osh_q;
  assign step       = dual_i ? 3'd2 : 3'd1;

  always_comb begin
    obuf_nx = obuf_q;
    full_nx = full_q;
    osh_nx  = osh_q;
    pos_nx  = pos_q;
    so_nx   = so_q;
    sio_nx  = sio_q;
    drv_nx  = drv_q;
    if (!rd_phase_i) begin
      full_nx = 1'b0;
      pos_nx  = '0;
      drv_nx  = 1'b0;
    end else begin
      if (take) begin
        obuf_nx = rd_data_i;
        full_nx = 1'b1;
      end
      if (shift_en_i) begin
        so_nx  = src[7];
        sio_nx = src[6];
        osh_nx = dual_i ? {src[5:0], 2'b00} : {src[6:0], 1'b0};
        pos_nx = pos_q + step;
        drv_nx = 1'b1;
        if ((pos_q == 3'd0) && !take) full_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q <= '0;
      full_q <= 1'b0;
      osh_q  <= '0;
      pos_q  <= '0;
      so_q   <= 1'b0;
      sio_q  <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      obuf_q <= obuf_nx;
      full_q <= full_nx;
      osh_q  <= osh_nx;
      pos_q  <= pos_nx;
      so_q   <= so_nx;
      sio_q  <= sio_nx;
      drv_q  <= drv_nx;
    end
  end

  assign so_o  = so_q;
  assign sio_o = sio_q;
  assign drv_o = drv_q;

  AST_DUAL_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    dual_i && rd_phase_i |-> !pos_q[0]); // R6

  AST_DRV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_phase_i |=> !drv_q); // R3

endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              sio_o,
  output logic              sio_oe_o,
  output logic              ev_valid_o,
  output logic [1:0]        ev_kind_o,
  output logic [ADDR_W-1:0] ev_data_o,
  input  logic              ev_ready_i,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              rd_ready_o,
  input  logic              busy_i,
  output logic              standby_o
);

  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_RST = 4'b1000;

  logic [PINS-1:0] pins_s;
  logic cs_n_s, sck_s, si_s, hold_n_s;
  logic cs_prev_q, sck_prev_q, hold_q, hold_nx;
  logic cs_fall, sck_rise, sck_fall;
  logic rise_en, fall_en;
  logic rd_phase, dual, drv_on;

  spi_fe_sync #(
    .W       (PINS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({hold_n_i, si_i, sck_i, cs_n_i}),
    .q_o   (pins_s)
  );

  assign {hold_n_s, si_s, sck_s, cs_n_s} = pins_s;

  assign cs_fall  = cs_prev_q && !cs_n_s;
  assign sck_rise = !sck_prev_q && sck_s;
  assign sck_fall = sck_prev_q && !sck_s;
  assign rise_en  = sck_rise && !hold_q && !cs_n_s;
  assign fall_en  = sck_fall && !hold_q && !cs_n_s;

  always_comb begin
    hold_nx = hold_q;
    if (cs_n_s)                               hold_nx = 1'b0;
    else if (!hold_q && !hold_n_s && !sck_s)  hold_nx = 1'b1;
    else if (hold_q && hold_n_s)              hold_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      cs_prev_q  <= cs_n_s;
      sck_prev_q <= sck_s;
      hold_q     <= hold_nx;
    end
  end

  spi_fe_rx #(
    .ADDR_W (ADDR_W)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .desel_i    (cs_n_s),
    .start_i    (cs_fall),
    .bit_en_i   (rise_en),
    .bit_i      (si_s),
    .ev_ready_i (ev_ready_i),
    .ev_valid_o (ev_valid_o),
    .ev_kind_o  (ev_kind_o),
    .ev_data_o  (ev_data_o),
    .rd_phase_o (rd_phase),
    .dual_o     (dual)
  );

  spi_fe_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_phase_i (rd_phase),
    .dual_i     (dual),
    .shift_en_i (fall_en),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .rd_ready_o (rd_ready_o),
    .so_o       (so_o),
    .sio_o      (sio_o),
    .drv_o      (drv_on)
  );

  assign so_oe_o   = !cs_n_s && !hold_q && drv_on;
  assign sio_oe_o  = so_oe_o && dual;
  assign standby_o = cs_n_s && !busy_i;

  AST_SO_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o |-> rd_phase); // R5

  AST_DESEL_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !rd_phase); // R3

endmodule

// File: tb/spi_flash_frontend_tb.sv
module spi_flash_frontend_tb;

  localparam int H  = 8;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n, cs_n_i, sck_i, si_i, hold_n_i;
  logic so_o, so_oe_o, sio_o, sio_oe_o;
  logic ev_valid_o, ev_ready_i, rd_valid_i, rd_ready_o, busy_i, standby_o;
  logic [1:0]  ev_kind_o;
  logic [23:0] ev_data_o;
  logic [7:0]  rd_data_i;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int core_idx = 0;
  logic [25:0] exp_q [$];

  always #10 clk = ~clk;

  spi_flash_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sck_i(sck_i), .si_i(si_i),
    .hold_n_i(hold_n_i), .so_o(so_o), .so_oe_o(so_oe_o), .sio_o(sio_o),
    .sio_oe_o(sio_oe_o), .ev_valid_o(ev_valid_o), .ev_kind_o(ev_kind_o),
    .ev_data_o(ev_data_o), .ev_ready_i(ev_ready_i), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .rd_ready_o(rd_ready_o), .busy_i(busy_i),
    .standby_o(standby_o)
  );

  function automatic logic [7:0] patt(int i);
    return 8'hA5 ^ 8'(i * 59 + 7);
  endfunction

  // controller model: serves pattern bytes in order, restarts per transaction
  assign rd_valid_i = 1'b1;
  assign rd_data_i  = patt(core_idx);
  always @(posedge clk) begin
    if (cs_n_i)          core_idx <= 0;
    else if (rd_ready_o) core_idx <= core_idx + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [23:0] d);
    exp_q.push_back({k, d});
  endtask

  // monitor: samples 2 ns before the rising edge where the handshake happens
  always @(negedge clk) begin
    #8;
    if (rst_n && ev_valid_o && ev_ready_i) begin
      if (exp_q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R1/R2: actual unexpected event %0h/%0h expected none", ev_kind_o, ev_data_o);
      end else begin
        logic [25:0] e;
        e = exp_q.pop_front();
        chk((e[25:24] == 2'd0) ? "R2 opcode" : (e[25:24] == 2'd1) ? "R4 address" : "R4 wdata",
            {6'd0, ev_kind_o, ev_data_o}, {6'd0, e});
      end
    end
  end

  task automatic bit_cycle(input logic b, input bit do_hold,
                           output logic s_so, output logic s_sio,
                           output logic s_oe, output logic s_sioe);
    sck_i = 1'b0;
    si_i  = b;
    if (do_hold) begin
      wclk(H);
      hold_n_i = 1'b0;
      wclk(6);
      chk("R7 so_oe in pause", {31'd0, so_oe_o}, 32'd0);
      chk("R7 sio_oe in pause", {31'd0, sio_oe_o}, 32'd0);
      for (int k = 0; k < 3; k++) begin
        si_i = ~si_i; sck_i = 1'b1; wclk(H);
        sck_i = 1'b0; wclk(H);
      end
      si_i = b;
      hold_n_i = 1'b1;
      wclk(6);
    end
    wclk(H - 1);
    s_so = so_o; s_sio = sio_o; s_oe = so_oe_o; s_sioe = sio_oe_o;
    wclk(1);
    sck_i = 1'b1;
    wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input int hold_at);
    logic a, b, c, d;
    for (int i = 7; i >= 0; i--) bit_cycle(v[i], (i == hold_at), a, b, c, d);
  endtask

  task automatic read_byte(input bit dual, input int hold_at, output logic [7:0] cap,
                           output logic oe_all, output logic sioe_all);
    logic a, b, c, d;
    cap = '0; oe_all = 1'b1; sioe_all = 1'b1;
    for (int i = 0; i < (dual ? 4 : 8); i++) begin
      bit_cycle(1'b0, (i == hold_at), a, b, c, d);
      cap = dual ? {cap[5:0], a, b} : {cap[6:0], a};
      oe_all &= c; sioe_all &= d;
    end
  endtask

  task automatic cs_start(input bit mode3);
    sck_i = mode3;
    wclk(4);
    cs_n_i = 1'b0;
    wclk(H);
  endtask

  task automatic cs_end(input bit mode3);
    if (!mode3) sck_i = 1'b0;
    wclk(H);
    cs_n_i = 1'b1;
    wclk(H);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    logic oe, sioe;
    rst_n = 1'b0; cs_n_i = 1'b0; sck_i = 1'b0; si_i = 1'b0;
    hold_n_i = 1'b1; ev_ready_i = 1'b1; busy_i = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(10);
    // reset state
    chk("R3 reset so_oe", {31'd0, so_oe_o}, 32'd0);
    chk("R8 reset ev_valid", {31'd0, ev_valid_o}, 32'd0);
    // R1: selected through reset, no falling edge -> nothing
    send_byte(8'h03, -1);
    send_byte(8'h11, -1);
    wclk(6);
    chk("R1 no start without falling cs", {31'd0, ev_valid_o}, 32'd0);
    cs_n_i = 1'b1; sck_i = 1'b0;
    wclk(H);

    // R3: activity while deselected ignored
    send_byte(8'hFF, -1);
    sck_i = 1'b0; wclk(6);
    chk("R3 deselected SI ignored", {31'd0, ev_valid_o}, 32'd0);

    // R9: standby
    chk("R9 standby idle", {31'd0, standby_o}, 32'd1);
    busy_i = 1'b1; wclk(2);
    chk("R9 standby while busy", {31'd0, standby_o}, 32'd0);
    busy_i = 1'b0; wclk(2);

    // R3: partial byte discarded, next transaction starts at opcode
    expect_ev(2'd0, 24'h000002);
    expect_ev(2'd1, 24'h0A0B0C);
    cs_start(1'b0);
    chk("R9 no standby when selected", {31'd0, standby_o}, 32'd0);
    send_byte(8'h02, -1);
    send_byte(8'h0A, -1); send_byte(8'h0B, -1); send_byte(8'h0C, -1);
    begin
      logic a, b, c, d;
      for (int i = 0; i < 5; i++) bit_cycle(1'b1, 1'b0, a, b, c, d);
    end
    cs_end(1'b0);
    expect_ev(2'd0, 24'h000099);
    expect_ev(2'd2, 24'h00005A);
    cs_start(1'b0);
    send_byte(8'h99, -1);
    send_byte(8'h5A, -1);
    cs_end(1'b0);

    // R7: pause during a write byte
    expect_ev(2'd0, 24'h000077);
    expect_ev(2'd2, 24'h000096);
    cs_start(1'b0);
    send_byte(8'h77, -1);
    send_byte(8'h96, 3);
    cs_end(1'b0);

    // R10: mode 3 program with address and data
    expect_ev(2'd0, 24'h000002);
    expect_ev(2'd1, 24'h000100);
    expect_ev(2'd2, 24'h0000C3);
    expect_ev(2'd2, 24'h00003C);
    cs_start(1'b1);
    send_byte(8'h02, -1);
    send_byte(8'h00, -1); send_byte(8'h01, -1); send_byte(8'h00, -1);
    send_byte(8'hC3, -1); send_byte(8'h3C, -1);
    cs_end(1'b1);
    sck_i = 1'b0; wclk(H);

    // R5: single read, pause in the second byte
    expect_ev(2'd0, 24'h000003);
    expect_ev(2'd1, 24'h123456);
    cs_start(1'b0);
    send_byte(8'h03, -1);
    send_byte(8'h12, -1); send_byte(8'h34, -1); send_byte(8'h56, -1);
    chk("R5 so_oe before first falling edge", {31'd0, so_oe_o}, 32'd0);
    for (int j = 0; j < 3; j++) begin
      read_byte(1'b0, (j == 1) ? 4 : -1, cap, oe, sioe);
      chk((j == 1) ? "R7 read byte after pause" : "R5 read byte", {24'd0, cap}, {24'd0, patt(j)});
      chk("R5 so_oe while reading", {31'd0, oe}, 32'd1);
      chk("R5 sio_oe stays low", {31'd0, sioe}, 32'd0);
    end
    cs_end(1'b0);
    chk("R3 so_oe after deselect", {31'd0, so_oe_o}, 32'd0);

    // R6: dual read
    expect_ev(2'd0, 24'h00003B);
    expect_ev(2'd1, 24'hABCDEF);
    cs_start(1'b0);
    send_byte(8'h3B, -1);
    send_byte(8'hAB, -1); send_byte(8'hCD, -1); send_byte(8'hEF, -1);
    for (int j = 0; j < 2; j++) begin
      read_byte(1'b1, -1, cap, oe, sioe);
      chk("R6 dual read byte", {24'd0, cap}, {24'd0, patt(j)});
      chk("R6 sio_oe in dual", {31'd0, sioe}, 32'd1);
    end
    cs_end(1'b0);
    chk("R3 sio_oe after deselect", {31'd0, sio_oe_o}, 32'd0);

    // R8: stalled handshake holds the opcode and drops the next byte
    ev_ready_i = 1'b0;
    cs_start(1'b0);
    send_byte(8'h55, -1);
    send_byte(8'hAA, -1);
    wclk(6);
    chk("R8 valid held", {31'd0, ev_valid_o}, 32'd1);
    chk("R8 payload held", {6'd0, ev_kind_o, ev_data_o}, 32'h00000055);
    expect_ev(2'd0, 24'h000055);
    ev_ready_i = 1'b1;
    wclk(4);
    chk("R8 pending-time byte dropped", {31'd0, ev_valid_o}, 32'd0);
    cs_end(1'b0);

    wclk(10);
    chk("R2 all expected events seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule